// File: doc/BRIEF.md
# Dual-Channel Filtered Input Capture Timer

This block timestamps edges on two external inputs. A 16-bit up-counter runs from a programmable division of the system clock. Each of the two capture channels synchronizes its input, can pass it through a majority-free noise filter that requires several agreeing samples, and watches it for a chosen edge. When that edge arrives, the channel copies the counter into its own capture register and sets a flag that stays set until software clears it.

Software controls the block through a small word-wide register port. Writes take effect on the clock edge and reads are combinational. A single internal prescaler provides every rate: the counter step rate and the filter sampling rate of each channel. A level interrupt output combines the flags with their per-channel enables.

Top module: `dual_capture_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, all control registers, both capture registers, flags, enables, synchronizers and filter state, and drives `irq` low. The prescaler is also cleared.
- R2: A write to address 0 loads `wr_data` into the counter at that clock edge, whether or not it is running. A load takes priority over an increment in the same cycle.
- R3: Address 1 is counter control. Bits 2:0 are a rate code k and bit 3 is run. The prescaler is a 7-bit counter that advances every cycle. The enable for code k is high in cycles where the low k prescaler bits are all ones, so it is high every cycle for k=0. With run=1 the counter adds 1 (modulo 2^16) in each enabled cycle. With run=0 it holds.
- R4: Addresses 2 and 3 control channels 0 and 1. Bits 5:4 pick the capturing edge: 00 none, 01 rising, 10 falling, 11 both.
- R5: With the filter off (control bit 3 = 0), an input change that is stable before clock edge 1 is recognized at clock edge 3, after a two-flop synchronizer. It is not recognized at edge 2.
- R6: Addresses 4 and 5 read the channel 0 and 1 capture registers. Writes to them are ignored. On a recognized edge, the register takes the counter value as it stood just before the recording clock edge.
- R7: With the filter on, control bits 2:0 pick a sampling rate code with the same enables as R3. On each enable the synchronized input is sampled. The filtered level moves to a new value only when that sample and the two preceding samples agree. A pulse seen in fewer than three samples is ignored.
- R8: Address 6 holds flag0 (bit 0), flag1 (bit 1), enable0 (bit 2) and enable1 (bit 3). A recognized edge sets its channel's flag. A write stores the enables from the data, clears a flag whose data bit is 0, and leaves a flag whose data bit is 1 unchanged.
- R9: If a capture event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag is set together with its enable.
- R11: Reads of unused bits return 0. Counter control reads back 4 bits, channel control reads back 6 bits, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 2 | Asynchronous capture inputs, bit i for channel i |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a software flag clear that lands in exactly the cycle in which a capture is recorded. The bench counts the synchronizer stages from the cycle in which it raises a pin and issues the clearing write so that it coincides with the third edge. It then reads back the flag. Filter glitch rejection is reached the same way: the bench holds a pulse for exactly two sampled cycles and then for three, at the fastest sampling rate. A long run of random pin activity and register writes then mixes every rate, edge mode and collision against the behavioural model.

// File: rtl/capt_pkg.sv
package capt_pkg;

    localparam int NUM_CH  = 2;
    localparam int RATE_W  = 3;
    localparam int EDGE_W  = 2;
    localparam int CHCTL_W = EDGE_W + 1 + RATE_W;
    localparam int CNCTL_W = 1 + RATE_W;

    typedef enum logic [EDGE_W-1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [2:0] {
        A_COUNT  = 3'd0,
        A_CNTCTL = 3'd1,
        A_CH0CTL = 3'd2,
        A_CH1CTL = 3'd3,
        A_CAP0   = 3'd4,
        A_CAP1   = 3'd5,
        A_IRQ    = 3'd6,
        A_VOID   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic              run;
        logic [RATE_W-1:0] rate;
    } cnt_ctl_t;

    typedef struct packed {
        edge_mode_e        edge_mode;
        logic              filt_on;
        logic [RATE_W-1:0] rate;
    } ch_ctl_t;

    function automatic logic edge_hit(edge_mode_e m, logic was, logic now);
        case (m)
            EDGE_RISE: return !was && now;
            EDGE_FALL: return was && !now;
            EDGE_BOTH: return was != now;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic           clk,
    input  logic           rst,
    output logic [PRE_W:0] tick
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k <= PRE_W; k++) begin : g_tick
        if (k == 0) begin : g_every
            assign tick[k] = 1'b1;
        end else begin : g_div
            assign tick[k] = &pre_q[k-1:0];
        end
    end

endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)                 count <= '0;
        else if (load)           count <= load_val;
        else if (run && step_en) count <= count + 1'b1;
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> count == $past(count)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R3

endmodule

// File: rtl/ct_capture_chan.sv
module ct_capture_chan
    import capt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  ch_ctl_t          ctl,
    input  logic             sample_tick,
    input  logic [CNT_W-1:0] count,
    output logic             evt,
    output logic [CNT_W-1:0] cap
);

    logic [1:0] sync_q;
    logic       smp;
    logic       lvl_q, lvl_n;
    logic [1:0] hist_q, hist_n;

    assign smp = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], pin};
    end

    always_comb begin
        lvl_n  = lvl_q;
        hist_n = hist_q;
        if (!ctl.filt_on) begin
            lvl_n  = smp;
            hist_n = {2{smp}};
        end else if (sample_tick) begin
            hist_n = {hist_q[0], smp};
            if (hist_q == {2{smp}}) lvl_n = smp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            hist_q <= '0;
        end else begin
            lvl_q  <= lvl_n;
            hist_q <= hist_n;
        end
    end

    assign evt = edge_hit(ctl.edge_mode, lvl_q, lvl_n);

    always_ff @(posedge clk) begin
        if (rst)      cap <= '0;
        else if (evt) cap <= count;
    end

    AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl.filt_on) && lvl_q != $past(lvl_q)) |-> $past(sample_tick)); // R7

    AST_CAP_ON_EVT: assert property (@(posedge clk) disable iff (rst)
        (cap != $past(cap)) |-> $past(evt)); // R6

endmodule

// File: rtl/ct_irq_flags.sv
module ct_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         wr,
    input  logic [N-1:0] wflags,
    input  logic [N-1:0] wen,
    output logic [N-1:0] flags,
    output logic [N-1:0] en,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            en    <= '0;
        end else begin
            if (wr) en <= wen;
            flags <= (wr ? (flags & wflags) : flags) | evt;
        end
    end

    assign irq = |(flags & en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !(wr && !wflags[i])) |=> flags[i]); // R8

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> flags[i]); // R9

        AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[i]) |-> $past(evt[i])); // R8
    end

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
    import capt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    cap_in,
    input  logic [2:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 irq
);

    logic [PRE_W:0]    tick;
    logic [CNT_W-1:0]  count;
    cnt_ctl_t          cnt_ctl;
    ch_ctl_t           ch_ctl [NUM_CH];
    logic [NUM_CH-1:0] evt;
    logic [CNT_W-1:0]  cap [NUM_CH];
    logic [NUM_CH-1:0] flags, en;
    logic              irq_wr;

    ct_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (cnt_ctl.run),
        .step_en  (tick[cnt_ctl.rate]),
        .load     (reg_wr && reg_addr == A_COUNT),
        .load_val (wr_data),
        .count    (count)
    );

    always_ff @(posedge clk) begin
        if (rst)                               cnt_ctl <= '0;
        else if (reg_wr && reg_addr == A_CNTCTL) cnt_ctl <= cnt_ctl_t'(wr_data[CNCTL_W-1:0]);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [2:0] CTL_ADDR = 3'(int'(A_CH0CTL) + i);

        always_ff @(posedge clk) begin
            if (rst)                                 ch_ctl[i] <= '0;
            else if (reg_wr && reg_addr == CTL_ADDR) ch_ctl[i] <= ch_ctl_t'(wr_data[CHCTL_W-1:0]);
        end

        ct_capture_chan #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .pin         (cap_in[i]),
            .ctl         (ch_ctl[i]),
            .sample_tick (tick[ch_ctl[i].rate]),
            .count       (count),
            .evt         (evt[i]),
            .cap         (cap[i])
        );
    end

    assign irq_wr = reg_wr && reg_addr == A_IRQ;

    ct_irq_flags #(.N(NUM_CH)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr     (irq_wr),
        .wflags (wr_data[NUM_CH-1:0]),
        .wen    (wr_data[2*NUM_CH-1:NUM_CH]),
        .flags  (flags),
        .en     (en),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(reg_addr))
            A_COUNT:  rd_data = count;
            A_CNTCTL: rd_data[CNCTL_W-1:0] = cnt_ctl;
            A_CH0CTL: rd_data[CHCTL_W-1:0] = ch_ctl[0];
            A_CH1CTL: rd_data[CHCTL_W-1:0] = ch_ctl[1];
            A_CAP0:   rd_data = cap[0];
            A_CAP1:   rd_data = cap[1];
            A_IRQ:    rd_data[2*NUM_CH-1:0] = {en, flags};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: tb/dual_capture_timer_tb_top.sv
module dual_capture_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  pin;
    logic [2:0]  addr;
    logic        wr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dual_capture_timer dut_i (
        .clk      (clk),
        .rst      (rst),
        .cap_in   (pin),
        .reg_addr (addr),
        .reg_wr   (wr),
        .wr_data  (wdata),
        .rd_data  (rdata),
        .irq      (irq)
    );

    // Behavioural reference, advanced on every rising edge from the bench's own inputs
    int          m_pre;
    logic [15:0] m_cnt;
    logic [3:0]  m_cctl;
    logic [5:0]  m_ctl  [2];
    logic        m_s1   [2];
    logic        m_s2   [2];
    logic        m_lvl  [2];
    logic [1:0]  m_hist [2];
    logic [15:0] m_cap  [2];
    logic [1:0]  m_flag, m_en, m_ev;

    function automatic bit on_rate(int pre, int k);
        return (pre % (1 << k)) == ((1 << k) - 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = '0; m_cctl = '0; m_flag = '0; m_en = '0;
            for (int i = 0; i < 2; i++) begin
                m_ctl[i] = '0; m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0;
                m_hist[i] = '0; m_cap[i] = '0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic nl, old;
                nl  = m_lvl[i];
                old = m_lvl[i];
                if (!m_ctl[i][3]) begin
                    nl = m_s2[i];
                    m_hist[i] = {m_s2[i], m_s2[i]};
                end else if (on_rate(m_pre, int'(m_ctl[i][2:0]))) begin
                    if (m_hist[i][1] == m_s2[i] && m_hist[i][0] == m_s2[i]) nl = m_s2[i];
                    m_hist[i] = {m_hist[i][0], m_s2[i]};
                end
                case (m_ctl[i][5:4])
                    2'b01:   m_ev[i] = !old && nl;
                    2'b10:   m_ev[i] = old && !nl;
                    2'b11:   m_ev[i] = old != nl;
                    default: m_ev[i] = 1'b0;
                endcase
                m_lvl[i] = nl;
                if (m_ev[i]) m_cap[i] = m_cnt;
            end
            if (wr && addr == 3'd0) m_cnt = wdata;
            else if (m_cctl[3] && on_rate(m_pre, int'(m_cctl[2:0]))) m_cnt = m_cnt + 16'd1;
            if (wr && addr == 3'd1) m_cctl = wdata[3:0];
            if (wr && addr == 3'd2) m_ctl[0] = wdata[5:0];
            if (wr && addr == 3'd3) m_ctl[1] = wdata[5:0];
            if (wr && addr == 3'd6) begin
                m_en   = wdata[3:2];
                m_flag = (m_flag & wdata[1:0]) | m_ev;
            end else begin
                m_flag = m_flag | m_ev;
            end
            for (int i = 0; i < 2; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = pin[i];
            end
            m_pre = (m_pre + 1) % 128;
        end
    end

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0:    return m_cnt;
            3'd1:    return {12'd0, m_cctl};
            3'd2:    return {10'd0, m_ctl[0]};
            3'd3:    return {10'd0, m_ctl[1]};
            3'd4:    return m_cap[0];
            3'd5:    return m_cap[1];
            3'd6:    return {12'd0, m_en, m_flag};
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0:       return "R3 counter";
            3'd1, 3'd2,
            3'd3:       return "R11 control";
            3'd4, 3'd5: return "R6 capture";
            3'd6:       return "R8 flags";
            default:    return "R11 unused";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        chk("R10 irq", {15'd0, irq}, {15'd0, |(m_flag & m_en)});
        chk(tag_of(addr), rdata, m_read(addr));
    endtask

    task automatic wreg(logic [2:0] a, logic [15:0] d);
        addr = a; wr = 1'b1; wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            addr = (addr == 3'd7) ? 3'd0 : addr + 3'd1;
            cyc();
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; pin = '0; addr = '0; wr = 1'b0; wdata = '0;
        repeat (5) cyc();
        rst = 1'b0;
        // R1: every register reads zero after reset
        for (int a = 0; a < 8; a++) rd("R1 reset", 3'(a), 16'h0000);
        chk("R1 irq low", {15'd0, irq}, 16'h0000);

        // R11: read-back widths
        wreg(3'd2, 16'hFFFF);
        rd("R11 ch ctl width", 3'd2, 16'h003F);
        wreg(3'd2, 16'h0000);
        wreg(3'd1, 16'hFFF5);
        rd("R11 cnt ctl width", 3'd1, 16'h0005);
        wreg(3'd7, 16'hFFFF);
        rd("R11 addr 7", 3'd7, 16'h0000);
        wreg(3'd4, 16'h5555);
        rd("R6 capture not writable", 3'd4, 16'h0000);

        // R2: load while stopped
        wreg(3'd0, 16'h1234);
        rd("R2 load stopped", 3'd0, 16'h1234);

        // R3: run at several rates, then wrap
        wreg(3'd1, 16'h0008);
        idle(20);
        wreg(3'd1, 16'h000A);
        idle(40);
        wreg(3'd1, 16'h0008);
        wreg(3'd0, 16'hFFFE);
        idle(4);
        // R2: load beats increment while running
        wreg(3'd0, 16'h0100);
        rd("R2 load while running", 3'd0, 16'h0100);
        // R3: stopped counter holds
        wreg(3'd1, 16'h0000);
        wreg(3'd0, 16'h00AA);
        idle(5);
        rd("R3 hold when stopped", 3'd0, 16'h00AA);

        // R5 / R6: unfiltered rising capture
        wreg(3'd2, 16'h0010);
        wreg(3'd6, 16'h0004);
        pin[0] = 1'b1;
        cyc(); cyc();
        rd("R5 not yet at edge 2", 3'd6, 16'h0004);
        cyc();
        rd("R5 flag at edge 3", 3'd6, 16'h0005);
        rd("R6 captured count", 3'd4, 16'h00AA);
        chk("R10 irq with enable", {15'd0, irq}, 16'h0001);

        // R9: clear lands on the recording edge
        pin[0] = 1'b0;
        repeat (4) cyc();
        pin[0] = 1'b1;
        cyc(); cyc();
        wreg(3'd6, 16'h0004);
        rd("R9 set wins over clear", 3'd6, 16'h0005);

        // R8: writing 1 keeps, writing 0 clears
        wreg(3'd6, 16'h0005);
        rd("R8 write one keeps", 3'd6, 16'h0005);
        wreg(3'd6, 16'h0004);
        rd("R8 write zero clears", 3'd6, 16'h0004);
        chk("R10 no flag no irq", {15'd0, irq}, 16'h0000);
        pin[0] = 1'b0; repeat (4) cyc();
        pin[0] = 1'b1; repeat (4) cyc();
        wreg(3'd6, 16'h0001);
        rd("R8 flag kept enable off", 3'd6, 16'h0001);
        chk("R10 disabled flag no irq", {15'd0, irq}, 16'h0000);
        wreg(3'd6, 16'h0000);

        // R4: edge modes
        wreg(3'd2, 16'h0020);
        wreg(3'd6, 16'h0004);
        pin[0] = 1'b0; repeat (4) cyc();
        rd("R4 falling captured", 3'd6, 16'h0005);
        wreg(3'd6, 16'h0004);
        pin[0] = 1'b1; repeat (4) cyc();
        rd("R4 rising ignored in fall mode", 3'd6, 16'h0004);
        wreg(3'd3, 16'h0000);
        wreg(3'd6, 16'h0008);
        pin[1] = 1'b1; repeat (4) cyc();
        pin[1] = 1'b0; repeat (4) cyc();
        rd("R4 mode none ignores edges", 3'd6, 16'h0008);
        wreg(3'd3, 16'h0030);
        pin[1] = 1'b1; repeat (4) cyc();
        rd("R4 both modes rise", 3'd6, 16'h000A);
        wreg(3'd6, 16'h0008);
        pin[1] = 1'b0; repeat (4) cyc();
        rd("R4 both modes fall", 3'd6, 16'h000A);

        // R7: filter at the fastest sampling rate
        wreg(3'd6, 16'h000C);
        wreg(3'd2, 16'h0018);
        pin[0] = 1'b0; repeat (8) cyc();
        wreg(3'd6, 16'h000C);
        pin[0] = 1'b1; cyc(); cyc();
        pin[0] = 1'b0; repeat (8) cyc();
        rd("R7 two-sample pulse rejected", 3'd6, 16'h000C);
        pin[0] = 1'b1; repeat (6) cyc();
        rd("R7 three samples accepted", 3'd6, 16'h000D);
        wreg(3'd2, 16'h002B);
        pin[0] = 1'b0;
        idle(60);

        // Mixed random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 2; i++)
                if ($urandom_range(0, 5) == 0) pin[i] = ~pin[i];
            if ($urandom_range(0, 9) == 0) begin
                addr  = 3'($urandom_range(0, 7));
                wr    = 1'b1;
                wdata = 16'($urandom());
            end else begin
                addr = 3'($urandom_range(0, 7));
                wr   = 1'b0;
            end
            cyc();
            wr = 1'b0;
        end

        summary();
    end

endmodule